// File: doc/BRIEF.md
# Masked Vector Load/Store Sequencer

This block runs one masked vector memory operation at a time. A start pulse captures a base address, a 256-bit mask vector, 256-bit store data, an element width (4 or 8 bytes), a vector length (128 or 256 bits), an address-size mask and a 64-bit-addressing flag. The block then steps through the enabled elements one memory request per cycle, over a plain request/response port. It finishes with a one-cycle done pulse and a fault flag.

The block checks all enabled addresses before it touches memory. A store runs a full probe pass to confirm that every target is writable, and only then writes. A load collects the returned elements into a 256-bit result and leaves disabled lanes at zero. The memory answers in the same cycle as the request: `rsp_err` and `rsp_rdata` are combinational functions of the request. A write takes effect at the clock edge that ends its request cycle.

Top module: `mvec_seq`

## Requirements
- R1: A lane is enabled when its sign bit in `elem_mask` is set. For 4-byte lanes this is bit 32n+31. For 8-byte lanes it is bit 64n+63. Disabled lanes generate no request.
- R2: Lane n uses the address (`base_addr` + n*4, or + n*8 for 8-byte lanes) AND `addr_mask`. The address wraps inside the mask.
- R3: When `addr64_mode` is 1 and any enabled lane address has bits 63:47 not all equal, the operation ends with `fault`=1 and issues no request.
- R4: A load (`is_store`=0) reads enabled lanes from the highest index to the lowest. Each 4-byte value goes to `ld_result[32n+:32]`, and each 8-byte value goes to `ld_result[64n+:64]` from `rsp_rdata[63:0]`. Disabled lanes read as zero.
- R5: A store first issues probe requests (`req_probe`=1, `req_we`=0) on the enabled lanes from the highest index down. It then issues write requests (`req_we`=1) from the lowest index up. The write data is the lane's slice of `store_data`, zero-extended to 64 bits for 4-byte lanes.
- R6: When `full_len`=0, only lanes 0..3 (4-byte) or lanes 0..1 (8-byte) are considered, and `ld_result[255:128]` is zero.
- R7: When `rsp_err`=1 during a probe or load request, the operation ends with `fault`=1 and issues no further request. A store that fails a probe writes nothing.
- R8: `done` is high for exactly one cycle per operation. A `start` that arrives while an operation is in progress is ignored.
- R9: A mask with no enabled lane finishes with `done`, with `fault`=0 and no request.
- R10: After reset, `done`, `fault` and `req_valid` are 0 and `ld_result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| is_store | input | 1 | 1 = store, 0 = load |
| wide_elem | input | 1 | 1 = 8-byte lanes, 0 = 4-byte lanes |
| full_len | input | 1 | 1 = 256-bit vector, 0 = 128-bit vector |
| base_addr | input | 64 | Address of lane 0 |
| elem_mask | input | 256 | Mask vector; lane sign bits enable lanes |
| store_data | input | 256 | Data for store lanes |
| addr_mask | input | 64 | Mask applied to every lane address |
| addr64_mode | input | 1 | Enables the canonical-address check |
| req_valid | output | 1 | A memory request is presented this cycle |
| req_addr | output | 64 | Request address |
| req_we | output | 1 | Request is a write |
| req_probe | output | 1 | Request is a writability probe |
| req_wide | output | 1 | Request is 8 bytes wide (else 4) |
| req_wdata | output | 64 | Write data |
| rsp_err | input | 1 | Memory rejects the current probe or read |
| rsp_rdata | input | 64 | Read data for the current request |
| ld_result | output | 256 | Assembled load result |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Operation aborted; valid with done |

## Verification
The inline assertions watch ordering on every cycle: load and probe indices strictly fall, write indices strictly rise, and the first write directly follows a probe. They also check that no request appears while a fault is shown, that `done` never lasts two cycles, and that a short load leaves the upper half of the result clear. Other properties need a memory model and complete scenarios, so only the bench can show them: exact lane addresses under wrap-around, returned data placement, the canonical check suppressing all traffic, probe failures preventing every write, and the rejection of a start pulse during a run.

// File: rtl/mvec_seq.sv
module mvec_seq #(
  parameter int AW       = 64,
  parameter int VW       = 256,
  parameter int CANON_LO = 47
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_store,
  input  logic          wide_elem,
  input  logic          full_len,
  input  logic [AW-1:0] base_addr,
  input  logic [VW-1:0] elem_mask,
  input  logic [VW-1:0] store_data,
  input  logic [AW-1:0] addr_mask,
  input  logic          addr64_mode,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic          req_we,
  output logic          req_probe,
  output logic          req_wide,
  output logic [63:0]   req_wdata,
  input  logic          rsp_err,
  input  logic [63:0]   rsp_rdata,
  output logic [VW-1:0] ld_result,
  output logic          done,
  output logic          fault
);
  localparam int NL = VW / 32;
  localparam int IW = $clog2(NL);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_PROBE, S_ACCESS, S_DONE} st_t;
  st_t st;

  logic          op_st, op_wide, op_full, op_lm, fault_q;
  logic [AW-1:0] base_q, amask_q;
  logic [VW-1:0] sdata_q, res_q, sd_sh;
  logic [NL-1:0] en_c, en_q, pend, bad, cur_oh, rest;
  logic [AW-1:0] lane_addr [NL];
  logic [IW-1:0] hi_idx, lo_idx, cur_idx;

  for (genvar n = 0; n < NL; n++) begin : g_lane
    logic dw_en, qw_en;
    assign dw_en = elem_mask[32*n+31] && (full_len || n < NL/2);
    if (n < NL/2) begin : g_q
      assign qw_en = elem_mask[64*n+63] && (full_len || n < NL/4);
    end else begin : g_nq
      assign qw_en = 1'b0;
    end
    assign en_c[n]      = wide_elem ? qw_en : dw_en;
    assign lane_addr[n] = (base_q + (op_wide ? AW'(n*8) : AW'(n*4))) & amask_q;
    assign bad[n]       = en_q[n] && !((&lane_addr[n][AW-1:CANON_LO]) || !(|lane_addr[n][AW-1:CANON_LO]));
  end

  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int n = 0; n < NL; n++) if (pend[n]) hi_idx = IW'(n);
    for (int n = NL-1; n >= 0; n--) if (pend[n]) lo_idx = IW'(n);
  end

  assign cur_idx   = (op_st && st == S_ACCESS) ? lo_idx : hi_idx;
  assign cur_oh    = NL'(1) << cur_idx;
  assign rest      = pend & ~cur_oh;
  assign sd_sh     = op_wide ? (sdata_q >> (64*cur_idx)) : (sdata_q >> (32*cur_idx));

  assign req_valid = (st == S_PROBE) || (st == S_ACCESS);
  assign req_probe = (st == S_PROBE);
  assign req_we    = (st == S_ACCESS) && op_st;
  assign req_wide  = op_wide;
  assign req_addr  = lane_addr[cur_idx];
  assign req_wdata = op_wide ? sd_sh[63:0] : {32'b0, sd_sh[31:0]};
  assign done      = (st == S_DONE);
  assign fault     = fault_q;
  assign ld_result = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {op_st, op_wide, op_full, op_lm, fault_q} <= '0;
      base_q <= '0; amask_q <= '0; sdata_q <= '0; res_q <= '0;
      en_q <= '0; pend <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_st <= is_store; op_wide <= wide_elem; op_full <= full_len; op_lm <= addr64_mode;
          base_q <= base_addr; amask_q <= addr_mask; sdata_q <= store_data;
          en_q <= en_c; res_q <= '0; fault_q <= 1'b0;
          st <= S_CHECK;
        end
        S_CHECK: begin
          if (op_lm && |bad) begin
            fault_q <= 1'b1; st <= S_DONE;
          end else if (en_q == '0) begin
            st <= S_DONE;
          end else begin
            pend <= en_q;
            st   <= op_st ? S_PROBE : S_ACCESS;
          end
        end
        S_PROBE: begin
          if (rsp_err) begin
            fault_q <= 1'b1; st <= S_DONE;
          end else if (rest == '0) begin
            pend <= en_q; st <= S_ACCESS;
          end else begin
            pend <= rest;
          end
        end
        S_ACCESS: begin
          if (!op_st && rsp_err) begin
            fault_q <= 1'b1; st <= S_DONE;
          end else begin
            if (!op_st)
              res_q <= res_q | (op_wide ? (VW'(rsp_rdata) << (64*cur_idx))
                                        : (VW'(rsp_rdata[31:0]) << (32*cur_idx)));
            pend <= rest;
            if (rest == '0) st <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_load_desc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && !req_probe && $past(req_valid && !req_we && !req_probe))
      |-> cur_idx < $past(cur_idx));
  p_probe_desc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_probe && $past(req_probe)) |-> cur_idx < $past(cur_idx));
  p_write_asc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we && $past(req_we)) |-> cur_idx > $past(cur_idx));
  p_write_after_probe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_we) |-> $past(req_probe));
  p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !req_valid);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_half_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_st && !op_full) |-> ld_result[VW-1:VW/2] == '0);
endmodule

// File: tb/mvec_seq_tb.sv
`timescale 1ns/1ps
module mvec_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic start = 0, is_store = 0, wide_elem = 0, full_len = 0, addr64_mode = 0;
  logic [63:0] base_addr = '0, addr_mask = '0;
  logic [255:0] elem_mask = '0, store_data = '0;
  logic req_valid, req_we, req_probe, req_wide, rsp_err, done, fault;
  logic [63:0] req_addr, req_wdata, rsp_rdata;
  logic [255:0] ld_result;

  always #2 clk = ~clk;

  mvec_seq dut_i (.clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
    .wide_elem(wide_elem), .full_len(full_len), .base_addr(base_addr), .elem_mask(elem_mask),
    .store_data(store_data), .addr_mask(addr_mask), .addr64_mode(addr64_mode),
    .req_valid(req_valid), .req_addr(req_addr), .req_we(req_we), .req_probe(req_probe),
    .req_wide(req_wide), .req_wdata(req_wdata), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ld_result(ld_result), .done(done), .fault(fault));

  int checks = 0, errors = 0;
  string cur_tag = "R10";
  logic [7:0] mem [256];
  bit err_on = 0;
  logic [63:0] err_addr = '0;
  logic [129:0] exp_q [$];

  always_comb begin
    for (int b = 0; b < 8; b++) rsp_rdata[8*b +: 8] = mem[8'(req_addr[7:0] + 8'(b))];
    rsp_err = err_on && req_valid && !req_we && (req_addr == err_addr);
  end

  always @(posedge clk)
    if (req_valid && req_we)
      for (int b = 0; b < (req_wide ? 8 : 4); b++) mem[8'(req_addr[7:0] + 8'(b))] = req_wdata[8*b +: 8];

  task automatic chk(bit ok, string tag, logic [255:0] act, logic [255:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // scoreboard monitor: each request is compared with the next expected item
  always @(negedge clk)
    if (rst_n && req_valid) begin
      logic [129:0] act;
      act = {req_we, req_probe, req_addr, req_we ? req_wdata : 64'h0};
      if (exp_q.size() == 0) chk(1'b0, {cur_tag, " unexpected request"}, 256'(act), 256'h0);
      else begin
        logic [129:0] e;
        e = exp_q.pop_front();
        chk(act == e, {cur_tag, " request"}, 256'(act), 256'(e));
      end
    end

  function automatic logic [63:0] rdm(logic [63:0] a, bit w);
    logic [63:0] v = '0;
    for (int b = 0; b < (w ? 8 : 4); b++) v[8*b +: 8] = mem[8'(a[7:0] + 8'(b))];
    return v;
  endfunction

  task automatic run_op(string tag, bit st, bit w, bit full, bit lm, logic [63:0] base,
                        logic [63:0] amask, logic [255:0] mask, logic [255:0] data, bit poke);
    int nl, esz, dcnt;
    logic [7:0] en;
    logic [63:0] la [8];
    logic [255:0] exp_res, t;
    bit exp_f, bad, hit;
    nl = w ? (full ? 4 : 2) : (full ? 8 : 4);
    esz = w ? 8 : 4;
    en = '0; exp_res = '0; exp_f = 0; bad = 0; hit = 0;
    exp_q.delete();
    for (int n = 0; n < 8; n++) la[n] = '0;
    for (int n = 0; n < nl; n++) begin
      t = mask >> (esz*8*n);
      en[n] = w ? t[63] : t[31];
      la[n] = (base + 64'(esz*n)) & amask;
      if (lm && en[n] && !(la[n][63:47] == '0 || la[n][63:47] == '1)) bad = 1;
    end
    if (bad) exp_f = 1;
    else if (st) begin
      for (int n = nl-1; n >= 0; n--)
        if (en[n] && !hit) begin
          exp_q.push_back({1'b0, 1'b1, la[n], 64'h0});
          if (err_on && la[n] == err_addr) hit = 1;
        end
      if (hit) exp_f = 1;
      else for (int n = 0; n < nl; n++)
        if (en[n]) begin
          t = data >> (esz*8*n);
          exp_q.push_back({1'b1, 1'b0, la[n], w ? t[63:0] : {32'h0, t[31:0]}});
        end
    end else begin
      for (int n = nl-1; n >= 0; n--)
        if (en[n] && !hit) begin
          exp_q.push_back({1'b0, 1'b0, la[n], 64'h0});
          if (err_on && la[n] == err_addr) hit = 1;
          else exp_res |= 256'(rdm(la[n], w)) << (esz*8*n);
        end
      if (hit) exp_f = 1;
    end
    cur_tag = tag;
    @(negedge clk);
    is_store = st; wide_elem = w; full_len = full; addr64_mode = lm;
    base_addr = base; addr_mask = amask; elem_mask = mask; store_data = data; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      is_store = !st; elem_mask = ~mask; base_addr = base + 64'h40; start = 1;
      @(negedge clk);
      start = 0; is_store = st; elem_mask = mask; base_addr = base;
    end
    dcnt = 0;
    for (int c = 0; c < 100 && dcnt == 0; c++) begin
      if (done) dcnt++;
      else @(negedge clk);
    end
    chk(dcnt == 1, {tag, " done seen"}, 256'(dcnt), 256'd1);
    chk(fault == exp_f, {tag, " fault"}, 256'(fault), 256'(exp_f));
    if (!st && !exp_f) chk(ld_result == exp_res, {tag, " load result"}, ld_result, exp_res);
    @(negedge clk);
    chk(!done, {tag, " R8 done single cycle"}, 256'(done), 256'h0);
    chk(exp_q.size() == 0, {tag, " all requests issued"}, 256'(exp_q.size()), 256'h0);
    repeat (2) begin
      @(negedge clk);
      chk(!req_valid && !done, {tag, " R8 quiet after done"}, 256'({req_valid, done}), 256'h0);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i*7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !fault && !req_valid && ld_result == '0, "R10 reset state",
        256'({done, fault, req_valid}), 256'h0);
    // R1 R2 R4: dword load, 256 bits, mixed sign bits
    run_op("R1 R4 dword load", 0, 0, 1, 0, 64'h20, 64'hFF,
           {32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h8000_0001, 32'h1, 32'h0, 32'h9000_0000}, '0, 0);
    // R1 R6: qword load, 128 bits; upper lane sign bits must be ignored
    run_op("R6 qword load half", 0, 1, 0, 0, 64'h40, 64'hFF, {256{1'b1}}, '0, 0);
    // R1: qword lane enable only by bit 63, not bit 31
    run_op("R1 qword enable bit", 0, 1, 1, 0, 64'h60, 64'hFF,
           {64'h8000_0000_0000_0000, 64'h0000_0000_8000_0000, 64'h8000_0000_0000_0000, 64'h0000_0000_FFFF_FFFF}, '0, 0);
    // R5: dword store then read back
    run_op("R5 dword store", 1, 0, 1, 0, 64'h80, 64'hFF,
           {32'h8000_0000, 32'h0, 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h8000_0000, 32'h0, 32'h8000_0000},
           256'h1111_1111_2222_2222_3333_3333_4444_4444_5555_5555_6666_6666_7777_7777_8888_8888, 0);
    run_op("R5 store readback", 0, 0, 1, 0, 64'h80, 64'hFF, {8{32'h8000_0000}}, '0, 0);
    // R5 R6: qword store, 128 bits
    run_op("R5 R6 qword store half", 1, 1, 0, 0, 64'hA0, 64'hFF, {256{1'b1}},
           256'hDEAD_BEEF_0000_0001_CAFE_F00D_0000_0002_0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 0);
    run_op("R6 readback", 0, 1, 1, 0, 64'hA0, 64'hFF, {256{1'b1}}, '0, 0);
    // R7: probe failure stops the store before any write
    err_on = 1; err_addr = 64'hC8;
    run_op("R7 probe fault", 1, 1, 1, 0, 64'hC0, 64'hFF, {256{1'b1}}, {4{64'hAAAA_5555_AAAA_5555}}, 0);
    // R7: read failure aborts a load
    run_op("R7 load fault", 0, 0, 1, 0, 64'hC0, 64'hFF, {256{1'b1}}, '0, 0);
    err_on = 0;
    run_op("R7 no write after fault", 0, 1, 1, 0, 64'hC0, 64'hFF, {256{1'b1}}, '0, 0);
    // R3: noncanonical lane in 64-bit mode
    run_op("R3 noncanonical", 0, 1, 1, 1, 64'h0000_7FFF_FFFF_FFF0, '1,
           {64'h0, 64'h8000_0000_0000_0000, 64'h0, 64'h8000_0000_0000_0000}, '0, 0);
    run_op("R3 noncanonical store", 1, 0, 1, 1, 64'hFFFF_7FFF_FFFF_FFF0, '1, {256{1'b1}}, '1, 0);
    run_op("R3 canonical ok", 0, 0, 1, 1, 64'hFFFF_8000_0000_0040, '1, {256{1'b1}}, '0, 0);
    // R9: empty mask
    run_op("R9 empty mask", 1, 0, 1, 0, 64'h10, 64'hFF, {8{32'h7FFF_FFFF}}, '1, 0);
    // R2: address wraps inside the mask
    run_op("R2 wrap", 0, 0, 1, 0, 64'hF8, 64'hFF, {256{1'b1}}, '0, 0);
    run_op("R2 wrap store", 1, 1, 1, 0, 64'h1F0, 64'hFF, {256{1'b1}}, {4{64'h0BAD_F00D_1234_5678}}, 0);
    // R8: start during a run is ignored
    run_op("R8 busy start", 0, 0, 1, 0, 64'h00, 64'hFF, {256{1'b1}}, '0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule